// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second operand of a 32-bit data-processing datapath. It takes the instruction's operand fields and a register operand, and returns the shifted value together with the shifter carry that the flag logic uses. The operand is either a small constant, which is rotated right by an even amount, or a register value. A register value is shifted left, shifted right with zero fill, shifted right with sign fill, or rotated. The shift amount comes either from a 5-bit field in the instruction or from the low byte of a second register.

Inside, a decode stage turns the encoded fields into simple controls: left, right, rotate, sign fill and carry insert, plus a 6-bit amount. On the immediate-amount path, an encoded amount of zero is given a new meaning. For right shifts it means a shift of 32. For rotate it means a one-bit rotate through the carry flag. A barrel stage then does the shift and clamps large amounts. The result, the carry and an undefined-encoding flag are held in output registers.

Top module: `opnd_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `result`, `carry_out` and `undefined` are all 0 after that edge.
- R2: Outputs are registered. Inputs present at a rising edge appear at the outputs just after that edge, and the outputs hold until the next edge.
- R3: When `imm_form`=1, `result` is `imm_val` zero-extended and rotated right by 2×`imm_rot`. `operand` is ignored. `carry_out` is `carry_in` when `imm_rot`=0, and `result[31]` otherwise.
- R4: `shift_kind` 00 is a left shift. With an instruction amount of 0, the operand passes unchanged and `carry_out`=`carry_in`. With an amount n from 1 to 31, `carry_out` is operand bit 32−n.
- R5: `shift_kind` 01 is a zero-fill right shift and 10 is a sign-fill right shift. An instruction amount of 0 means a shift of 32. For an amount n from 1 to 31, `carry_out` is operand bit n−1.
- R6: `shift_kind` 11 with a non-zero instruction amount is a true rotate right, and `carry_out`=`result[31]`. With an instruction amount of 0, the result is {`carry_in`, operand[31:1]} and `carry_out` is operand bit 0.
- R7: When `amt_from_reg`=1, only `amt_reg_val[7:0]` is used as the amount. An amount of 0 passes the operand unchanged with `carry_out`=`carry_in`, for every shift kind.
- R8: For a register amount on a left or zero-fill right shift, an amount of exactly 32 gives 0. Then `carry_out` is operand bit 0 for a left shift and bit 31 for a right shift. Amounts from 33 to 255 give 0 with `carry_out`=0.
- R9: For a register amount of 32 to 255 on a sign-fill right shift, every result bit and `carry_out` equal operand bit 31.
- R10: A register-amount rotate turns by the amount modulo 32. A non-zero multiple of 32 leaves the operand unchanged, with `carry_out`=operand bit 31.
- R11: `undefined` is 1 exactly when `imm_form`=0, `amt_from_reg`=1 and `reserved_bit`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 32 | Register operand to shift |
| carry_in | input | 1 | Current carry flag |
| imm_form | input | 1 | 1: constant operand, 0: register operand |
| imm_val | input | 8 | Constant before rotation |
| imm_rot | input | 4 | Half of the constant's rotate amount |
| shift_kind | input | 2 | 00 left, 01 zero-fill right, 10 sign-fill right, 11 rotate |
| amt_from_reg | input | 1 | Amount taken from `amt_reg_val` |
| amt_field | input | 5 | Amount from the instruction |
| amt_reg_val | input | 32 | Register holding the shift amount |
| reserved_bit | input | 1 | Encoding bit that must be 0 for the register-amount form |
| result | output | 32 | Shifted operand (registered) |
| carry_out | output | 1 | Shifter carry (registered) |
| undefined | output | 1 | Reserved-encoding flag (registered) |

## Verification
The logic between inputs and outputs is combinational, and every result passes through one output register. So `result`, `carry_out` and `undefined` are due one rising edge after their inputs are applied. The bench changes inputs on a falling edge and compares on the next falling edge, which is half a period after the capturing edge. One scenario also samples just after new inputs are applied, before the edge, to confirm that the outputs still show the previous result. The bound properties relate each output to the inputs of the previous cycle through `|=>` and `$past` of depth one.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic shl;
    logic shr;
    logic rot;
    logic sext;
    logic ins_carry;
  } shift_ctl_t;

endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
  import opsh_pkg::*;
#(
  parameter int DW   = 32,
  parameter int SFW  = 5,
  parameter int ROTW = 4,
  parameter int AMW  = SFW + 1
) (
  input  logic            imm_form,
  input  logic [ROTW-1:0] imm_rot,
  input  logic [1:0]      shift_kind,
  input  logic            amt_from_reg,
  input  logic [SFW-1:0]  amt_field,
  input  logic            reserved_bit,
  output shift_ctl_t      ctl,
  output logic [AMW-1:0]  imm_amt,
  output logic            undef_enc
);

  localparam logic [AMW-1:0] FULL = AMW'(DW);
  localparam logic [AMW-1:0] ONE  = AMW'(1);

  shift_kind_e kind;
  assign kind = shift_kind_e'(shift_kind);

  always_comb begin
    ctl     = '0;
    imm_amt = '0;
    if (imm_form) begin
      ctl.rot = 1'b1;
      imm_amt = AMW'({imm_rot, 1'b0});
    end else begin
      imm_amt = AMW'(amt_field);
      unique case (kind)
        SK_LSL: ctl.shl = 1'b1;
        SK_LSR: ctl.shr = 1'b1;
        SK_ASR: begin
          ctl.shr  = 1'b1;
          ctl.sext = 1'b1;
        end
        default: ctl.rot = 1'b1;
      endcase
      if (!amt_from_reg && (amt_field == '0)) begin
        unique case (kind)
          SK_LSR, SK_ASR: imm_amt = FULL;
          SK_ROR: begin
            ctl.rot       = 1'b0;
            ctl.ins_carry = 1'b1;
            imm_amt       = ONE;
          end
          default: imm_amt = '0;
        endcase
      end
    end
  end

  assign undef_enc = ~imm_form & amt_from_reg & reserved_bit;

endmodule

// File: rtl/opsh_src_sel.sv
module opsh_src_sel #(
  parameter int DW  = 32,
  parameter int IMW = 8,
  parameter int AW  = 8,
  parameter int AMW = 6
) (
  input  logic           imm_form,
  input  logic           amt_from_reg,
  input  logic [DW-1:0]  operand,
  input  logic [IMW-1:0] imm_val,
  input  logic [AMW-1:0] imm_amt,
  input  logic [DW-1:0]  amt_reg_val,
  output logic [DW-1:0]  src,
  output logic [AW-1:0]  amt
);

  localparam int PADW = AW - AMW;

  generate
    if (PADW > 0) begin : g_pad
      assign amt = (amt_from_reg && !imm_form) ? amt_reg_val[AW-1:0]
                                               : {{PADW{1'b0}}, imm_amt};
    end else begin : g_nopad
      assign amt = (amt_from_reg && !imm_form) ? amt_reg_val[AW-1:0]
                                               : imm_amt[AW-1:0];
    end
  endgenerate

  assign src = imm_form ? {{(DW-IMW){1'b0}}, imm_val} : operand;

endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic [DW-1:0] src,
  input  logic [AW-1:0] amt,
  input  shift_ctl_t    ctl,
  input  logic          carry_in,
  output logic [DW-1:0] res,
  output logic          cout
);

  localparam int            RW  = $clog2(DW);
  localparam logic [AW-1:0] SAT = AW'(DW + 1);

  logic [AW-1:0]     amt_sat;
  logic [RW-1:0]     rot_amt;
  logic [2*DW-1:0]   lvec;
  logic [2*DW+1:0]   rvec;
  logic [2*DW-1:0]   rotv;
  logic              fill;

  assign amt_sat = (amt > SAT) ? SAT : amt;
  assign rot_amt = amt[RW-1:0];
  assign fill    = ctl.sext & src[DW-1];
  assign lvec    = {{DW{1'b0}}, src} << amt_sat;
  assign rvec    = {{(DW+1){fill}}, src, 1'b0} >> amt_sat;
  assign rotv    = {src, src} >> rot_amt;

  always_comb begin
    res  = src;
    cout = carry_in;
    if (ctl.ins_carry) begin
      res  = {carry_in, src[DW-1:1]};
      cout = src[0];
    end else if (amt == '0) begin
      res  = src;
      cout = carry_in;
    end else if (ctl.rot) begin
      res  = rotv[DW-1:0];
      cout = rotv[DW-1];
    end else if (ctl.shr) begin
      res  = rvec[DW:1];
      cout = rvec[0];
    end else begin
      res  = lvec[DW-1:0];
      cout = lvec[DW];
    end
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opsh_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IMW  = 8,
  parameter int ROTW = 4,
  parameter int SFW  = 5,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   operand,
  input  logic            carry_in,
  input  logic            imm_form,
  input  logic [IMW-1:0]  imm_val,
  input  logic [ROTW-1:0] imm_rot,
  input  logic [1:0]      shift_kind,
  input  logic            amt_from_reg,
  input  logic [SFW-1:0]  amt_field,
  input  logic [DW-1:0]   amt_reg_val,
  input  logic            reserved_bit,
  output logic [DW-1:0]   result,
  output logic            carry_out,
  output logic            undefined
);

  localparam int AMW = SFW + 1;

  shift_ctl_t     ctl;
  logic [AMW-1:0] imm_amt;
  logic           undef_enc;
  logic [DW-1:0]  src;
  logic [AW-1:0]  amt;
  logic [DW-1:0]  res_d;
  logic           cout_d;

  opsh_decode #(.DW(DW), .SFW(SFW), .ROTW(ROTW), .AMW(AMW)) u_decode (
    .imm_form     (imm_form),
    .imm_rot      (imm_rot),
    .shift_kind   (shift_kind),
    .amt_from_reg (amt_from_reg),
    .amt_field    (amt_field),
    .reserved_bit (reserved_bit),
    .ctl          (ctl),
    .imm_amt      (imm_amt),
    .undef_enc    (undef_enc)
  );

  opsh_src_sel #(.DW(DW), .IMW(IMW), .AW(AW), .AMW(AMW)) u_src (
    .imm_form     (imm_form),
    .amt_from_reg (amt_from_reg),
    .operand      (operand),
    .imm_val      (imm_val),
    .imm_amt      (imm_amt),
    .amt_reg_val  (amt_reg_val),
    .src          (src),
    .amt          (amt)
  );

  opsh_barrel #(.DW(DW), .AW(AW)) u_barrel (
    .src      (src),
    .amt      (amt),
    .ctl      (ctl),
    .carry_in (carry_in),
    .res      (res_d),
    .cout     (cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      undefined <= 1'b0;
    end else begin
      result    <= res_d;
      carry_out <= cout_d;
      undefined <= undef_enc;
    end
  end

endmodule

// File: rtl/opsh_checker.sv
module opsh_checker #(
  parameter int DW   = 32,
  parameter int IMW  = 8,
  parameter int ROTW = 4,
  parameter int SFW  = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [DW-1:0]   operand,
  input logic            carry_in,
  input logic            imm_form,
  input logic [IMW-1:0]  imm_val,
  input logic [ROTW-1:0] imm_rot,
  input logic [1:0]      shift_kind,
  input logic            amt_from_reg,
  input logic [SFW-1:0]  amt_field,
  input logic [DW-1:0]   amt_reg_val,
  input logic            reserved_bit,
  input logic [DW-1:0]   result,
  input logic            carry_out,
  input logic            undefined
);

  logic reg_path;
  assign reg_path = !imm_form && amt_from_reg;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry_out && !undefined));

  // R11
  a_r11_undef_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (undefined == $past(!imm_form && amt_from_reg && reserved_bit)));

  // R3
  a_r3_imm_norot: assert property (@(posedge clk) disable iff (rst)
    (imm_form && imm_rot == '0) |=>
      (result == {{(DW-IMW){1'b0}}, $past(imm_val)} && carry_out == $past(carry_in)));

  // R6
  a_r6_rrx: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && !amt_from_reg && shift_kind == 2'b11 && amt_field == '0) |=>
      (result == {$past(carry_in), $past(operand[DW-1:1])} && carry_out == $past(operand[0])));

  // R7
  a_r7_reg_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_path && amt_reg_val[7:0] == 8'd0) |=>
      (result == $past(operand) && carry_out == $past(carry_in)));

  // R8
  a_r8_lsl_over: assert property (@(posedge clk) disable iff (rst)
    (reg_path && shift_kind == 2'b00 && amt_reg_val[7:0] > 8'd32) |=>
      (result == '0 && !carry_out));

  // R9
  a_r9_asr_fill: assert property (@(posedge clk) disable iff (rst)
    (reg_path && shift_kind == 2'b10 && amt_reg_val[7:0] >= 8'd32) |=>
      (result == {DW{$past(operand[DW-1])}} && carry_out == $past(operand[DW-1])));

endmodule

bind opnd_shifter opsh_checker #(.DW(DW), .IMW(IMW), .ROTW(ROTW), .SFW(SFW)) u_opsh_chk (
  .clk          (clk),
  .rst          (rst),
  .operand      (operand),
  .carry_in     (carry_in),
  .imm_form     (imm_form),
  .imm_val      (imm_val),
  .imm_rot      (imm_rot),
  .shift_kind   (shift_kind),
  .amt_from_reg (amt_from_reg),
  .amt_field    (amt_field),
  .amt_reg_val  (amt_reg_val),
  .reserved_bit (reserved_bit),
  .result       (result),
  .carry_out    (carry_out),
  .undefined    (undefined)
);

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand = '0;
  logic        carry_in = 1'b0;
  logic        imm_form = 1'b0;
  logic [7:0]  imm_val = '0;
  logic [3:0]  imm_rot = '0;
  logic [1:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  amt_field = '0;
  logic [31:0] amt_reg_val = '0;
  logic        reserved_bit = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  logic        undefined;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  opnd_shifter u_opnd_shifter (
    .clk(clk), .rst(rst), .operand(operand), .carry_in(carry_in),
    .imm_form(imm_form), .imm_val(imm_val), .imm_rot(imm_rot),
    .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
    .amt_field(amt_field), .amt_reg_val(amt_reg_val),
    .reserved_bit(reserved_bit), .result(result),
    .carry_out(carry_out), .undefined(undefined)
  );

  // Independent model: step one bit at a time.
  function automatic logic [32:0] model();
    logic [31:0] v;
    logic        c;
    int          n;
    c = carry_in;
    if (imm_form) begin
      v = {24'd0, imm_val};
      for (int i = 0; i < 2 * imm_rot; i++) begin
        c = v[0];
        v = {v[0], v[31:1]};
      end
      return {c, v};
    end
    v = operand;
    n = amt_from_reg ? int'(amt_reg_val[7:0]) : int'(amt_field);
    if (!amt_from_reg && n == 0) begin
      if (shift_kind == 2'b01 || shift_kind == 2'b10) n = 32;
      if (shift_kind == 2'b11) return {operand[0], carry_in, operand[31:1]};
    end
    for (int i = 0; i < n; i++) begin
      case (shift_kind)
        2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic cmp(input string req, input logic [31:0] er, input logic ec,
                     input logic eu);
    checks++;
    if (result !== er || carry_out !== ec || undefined !== eu) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b u=%b, expected res=%h c=%b u=%b",
               req, result, carry_out, undefined, er, ec, eu);
    end
  endtask

  // Inputs are already set (at a falling edge); check at the next falling edge.
  task automatic go(input string req);
    logic [32:0] e;
    logic        eu;
    e  = model();
    eu = !imm_form && amt_from_reg && reserved_bit;
    @(negedge clk);
    cmp(req, e[31:0], e[32], eu);
  endtask

  task automatic set_reg(input logic [1:0] k, input logic by_reg,
                         input logic [4:0] f, input logic [31:0] rv);
    imm_form = 1'b0; shift_kind = k; amt_from_reg = by_reg;
    amt_field = f; amt_reg_val = rv; reserved_bit = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    operand = 32'hFFFF_FFFF; carry_in = 1'b1; imm_form = 1'b1;
    imm_val = 8'hFF;
    repeat (2) @(negedge clk);
    cmp("R1 reset", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_imm_operand();
    operand = 32'hDEAD_BEEF;
    imm_form = 1'b1; imm_val = 8'hA5; carry_in = 1'b1;
    imm_rot = 4'd0; go("R3 rot0 keeps carry");
    imm_rot = 4'd1; go("R3 rot by 2");
    imm_rot = 4'd4; go("R3 rot by 8");
    imm_val = 8'h3C; carry_in = 1'b0; imm_rot = 4'd15; go("R3 rot by 30");
    cmp("R3 rot30 value", 32'h0000_00F0, 1'b0, 1'b0);
  endtask

  task automatic t_imm_shift();
    int amts[3] = '{0, 1, 31};
    operand = 32'h8000_0001; carry_in = 1'b1;
    for (int k = 0; k < 4; k++) begin
      foreach (amts[i]) begin
        set_reg(2'(k), 1'b0, 5'(amts[i]), 32'h0);
        case (k)
          0: go("R4 lsl imm");
          1, 2: go("R5 right imm");
          default: go("R6 ror imm");
        endcase
      end
    end
    operand = 32'h8000_0000; set_reg(2'b01, 1'b0, 5'd0, 0); go("R5 lsr 0 means 32");
    cmp("R5 lsr32 value", 32'h0, 1'b1, 1'b0);
    set_reg(2'b10, 1'b0, 5'd0, 0); go("R5 asr 0 means 32");
    cmp("R5 asr32 value", 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_rrx();
    operand = 32'h0000_0003; carry_in = 1'b1;
    set_reg(2'b11, 1'b0, 5'd0, 0); go("R6 rrx");
    cmp("R6 rrx value", 32'h8000_0001, 1'b1, 1'b0);
    carry_in = 1'b0; operand = 32'hFFFF_FFFE; go("R6 rrx carry0");
    cmp("R6 rrx carry0 value", 32'h7FFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_reg_shift();
    int amts[6] = '{0, 1, 31, 32, 33, 255};
    operand = 32'hC000_0003; carry_in = 1'b1;
    for (int k = 0; k < 4; k++) begin
      foreach (amts[i]) begin
        set_reg(2'(k), 1'b1, 5'd7, 32'(amts[i]));
        case (k)
          0, 1: go("R8 reg lsl/lsr");
          2: go("R9 reg asr");
          default: go("R10 reg ror");
        endcase
      end
    end
    set_reg(2'b00, 1'b1, 5'd0, 32'd32); go("R8 lsl32");
    cmp("R8 lsl32 value", 32'h0, 1'b1, 1'b0);
    set_reg(2'b11, 1'b1, 5'd0, 32'd64); go("R10 ror64");
    cmp("R10 ror64 value", 32'hC000_0003, 1'b1, 1'b0);
    set_reg(2'b01, 1'b1, 5'd0, 32'hFFFF_FF00); carry_in = 1'b0; go("R7 high bits ignored");
    cmp("R7 zero amount value", 32'hC000_0003, 1'b0, 1'b0);
    set_reg(2'b00, 1'b1, 5'd0, 32'h0000_0104); go("R7 low byte used");
    cmp("R7 low byte value", 32'h0000_0030, 1'b0, 1'b0);
  endtask

  task automatic t_undef();
    operand = 32'h1234_5678;
    set_reg(2'b00, 1'b1, 5'd0, 32'd2); reserved_bit = 1'b1; go("R11 undefined set");
    set_reg(2'b00, 1'b0, 5'd2, 32'd2); reserved_bit = 1'b1; go("R11 imm amount clear");
    imm_form = 1'b1; amt_from_reg = 1'b1; go("R11 imm operand clear");
  endtask

  task automatic t_latency();
    logic [31:0] prev_r;
    logic        prev_c;
    operand = 32'h0000_00F0; set_reg(2'b00, 1'b0, 5'd4, 0); go("R2 first");
    prev_r = result; prev_c = carry_out;
    operand = 32'hFFFF_FFFF; set_reg(2'b01, 1'b0, 5'd8, 0);
    #1 cmp("R2 holds before edge", prev_r, prev_c, 1'b0);
    go("R2 after edge");
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      operand = $urandom; carry_in = 1'($urandom);
      imm_form = ($urandom % 4) == 0; imm_val = 8'($urandom); imm_rot = 4'($urandom);
      shift_kind = 2'($urandom); amt_from_reg = 1'($urandom);
      amt_field = 5'($urandom); amt_reg_val = $urandom; reserved_bit = 1'($urandom);
      go("R3-R11 random");
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_imm_operand();
    t_imm_shift();
    t_rrx();
    t_reg_shift();
    t_undef();
    t_latency();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule